// File: doc/BRIEF.md
# Two-Channel Down-Counter Timer

A timer peripheral with two independent count-down channels behind a simple register bus. Software writes a 56-bit interval, split into a 32-bit low word and a 24-bit high word. It then starts the channel through a control word. The control word enables counting, can request a one-time copy of the interval into the counter, picks a power-of-two tick divider, and chooses periodic or one-shot mode. When the counter has reached zero and takes one more tick, the channel expires. Expiry sets that channel's status flag. A periodic channel then reloads from its interval. A one-shot channel clears its own enable and holds at zero. Status flags are write-one-to-clear. A single level interrupt output is driven high while any flagged channel also has its interrupt enable bit set.

Each channel is sequenced by a four-state machine:
- IDLE: the counter holds.
- ARM: a start-up synchronisation wait of SYNC clock cycles.
- RUN: the counter decrements on prescaled ticks.
- DRAIN: after the enable is cleared, the counter keeps ticking for SYNC more clock cycles before it stops.

The transitions are:
- start: IDLE to ARM when enable is set.
- armed: ARM to RUN when the wait has elapsed.
- abort: ARM to IDLE when enable drops during the wait.
- stop: RUN to DRAIN when enable is cleared.
- drained: DRAIN to IDLE when the drain wait has elapsed.
- fire-once: RUN or DRAIN to IDLE on a one-shot expiry.

Software-visible counting values are the count words. Inverting the count low word gives a value that rises over time. An all-ones interval in periodic mode gives a counter that wraps and runs freely.

Top module: `tmr_block`

## Requirements
- R1: After reset, every register reads zero, no channel counts and `irq` is low.
- R2: Register map (byte addresses; accesses with nonzero address bits 1:0 are ignored and read zero):
  - 0x00 is the interrupt enable register, bit n for channel n.
  - 0x04 is the status register.
  - Channel n uses base 0x20*n+0x10, with these words: +0x0 control, +0x4 interval low, +0x8 interval high (24 bits), +0xC count low, +0x10 count high.
  - Count words are read-only.
  - Any other address reads zero and ignores writes.
- R3: Control fields: bit 0 enable, bit 1 reload request (reads back as 0), bits 6:4 prescaler select k, bit 7 one-shot (0 selects periodic). Bits 3:2 and 31:8 read zero. Writing enable as 0 shows at once in the readback.
- R4: A control write with bit 1 set copies the interval into the counter on the next clock edge. The count read just after the write edge still holds the old value.
- R5: When enable and reload are written together at edge W, the channel waits in ARM and enters RUN at edge W+3 (SYNC=2). Its status flag then sets at edge W+3+(I+1)*2^k, where I is the interval.
- R6: While running, the counter decrements by one every 2^k clock cycles, with borrow from the low word into the high word.
- R7: In periodic mode, expiry reloads the interval, so the status flag sets again every (I+1)*2^k cycles.
- R8: In one-shot mode, expiry sets the status flag, clears the enable bit (control bit 0 reads 0) and leaves the count at zero.
- R9: Writing 1 to status bit n clears channel n's flag. Writing 0 leaves the flag unchanged. A flag being set wins over a clear in the same cycle.
- R10: `irq` is high exactly while some channel has both its status flag and its interrupt enable bit set, and it stays high until software clears the flag or the enable.
- R11: After enable is cleared in RUN, the counter takes SYNC+1 further clock cycles of ticks (3 decrements at k=0) and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Combined level interrupt |

## Verification
A channel machine stuck in the wrong state shows up in how long it takes to expire. Staying in ARM, or skipping it, moves the status flag by whole cycles relative to 3+(I+1)*2^k, and this is seen within a few tens of cycles across the interval and prescaler sweep. A wrong drain length or a missed stop shows in the count word within a handful of cycles of the disable write. A missed one-shot halt shows at once in the control readback and the count word after the expiry edge. Status, enable and irq faults show as soon as the flag is set or cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARM   = 2'd1,
        CH_RUN   = 2'd2,
        CH_DRAIN = 2'd3
    } ch_state_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [PW-1:0] sel,
    output logic          tick
);
    localparam int MW = 1 << PW;

    logic [MW-1:0] div_cnt;
    logic [MW-1:0] mask;

    assign mask = (MW'(1) << sel) - MW'(1);
    assign tick = active && ((div_cnt & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_cnt <= '0;
        else if (!active) div_cnt <= '0;
        else if (tick)    div_cnt <= '0;
        else              div_cnt <= div_cnt + MW'(1);
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int LOW_W  = 32,
    parameter int HIGH_W = 24,
    parameter int PW     = 3,
    parameter int SYNC   = 2,
    parameter int DW     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctrl_we,
    input  logic                    ilo_we,
    input  logic                    ihi_we,
    input  logic [DW-1:0]           wdata,
    output logic [7:0]              ctrl_q,
    output logic [LOW_W+HIGH_W-1:0] interval,
    output logic [LOW_W+HIGH_W-1:0] count,
    output logic                    expire
);
    localparam int CW = LOW_W + HIGH_W;
    localparam int SW = $clog2(SYNC) + 1;

    ch_state_t     state, state_nx;
    logic          en_q, oneshot_q, reload_pend;
    logic [PW-1:0] presc_q;
    logic [SW-1:0] sync_cnt;
    logic          counting, tick, sync_done;

    tmr_prescaler #(.PW(PW)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (counting),
        .sel    (presc_q),
        .tick   (tick)
    );

    assign ctrl_q = {oneshot_q, presc_q, 2'b00, 1'b0, en_q};

    // Machine outputs
    always_comb begin
        counting  = (state == CH_RUN) || (state == CH_DRAIN);
        sync_done = (sync_cnt == SW'(SYNC - 1));
        expire    = tick && (count == '0) && !reload_pend;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE:  if (en_q) state_nx = CH_ARM;
            CH_ARM:   if (!en_q) state_nx = CH_IDLE;
                      else if (sync_done) state_nx = CH_RUN;
            CH_RUN:   if (expire && oneshot_q) state_nx = CH_IDLE;
                      else if (!en_q) state_nx = CH_DRAIN;
            CH_DRAIN: if ((expire && oneshot_q) || sync_done) state_nx = CH_IDLE;
            default:  state_nx = CH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_cnt <= '0;
        end else if (state_nx != state) begin
            sync_cnt <= '0;
        end else if (state == CH_ARM || state == CH_DRAIN) begin
            sync_cnt <= sync_cnt + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            oneshot_q   <= 1'b0;
            presc_q     <= '0;
            reload_pend <= 1'b0;
        end else begin
            reload_pend <= ctrl_we && wdata[1];
            if (ctrl_we) begin
                en_q      <= wdata[0];
                presc_q   <= wdata[4 +: PW];
                oneshot_q <= wdata[7];
            end else if (expire && oneshot_q) begin
                en_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            interval <= '0;
        end else begin
            if (ilo_we) interval[LOW_W-1:0]  <= wdata[LOW_W-1:0];
            if (ihi_we) interval[CW-1:LOW_W] <= wdata[HIGH_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (reload_pend) begin
            count <= interval;
        end else if (tick) begin
            if (count != '0)     count <= count - CW'(1);
            else if (!oneshot_q) count <= interval;
        end
    end

    assert_reload_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pend |=> count == $past(interval));
    assert_oneshot_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && oneshot_q && !ctrl_we) |=> (state == CH_IDLE && count == '0 && !en_q));
    assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != '0 && !reload_pend) |=> count == $past(count) - CW'(1));
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE && !reload_pend) |=> $stable(count));
    assert_drain_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_DRAIN) |-> sync_cnt < SW'(SYNC));
endmodule

// File: rtl/tmr_block.sv
module tmr_block #(
    parameter int NCH    = 2,
    parameter int LOW_W  = 32,
    parameter int HIGH_W = 24,
    parameter int PW     = 3,
    parameter int SYNC   = 2,
    parameter int AW     = 8,
    parameter int DW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam int CW         = LOW_W + HIGH_W;
    localparam int REG_BASE   = 16;
    localparam int REG_STRIDE = 32;
    localparam int CH_SPAN    = 20;
    localparam logic [AW-1:0] IEN_ADDR = AW'(0);
    localparam logic [AW-1:0] STS_ADDR = AW'(4);

    logic           aligned, wr_go;
    logic [NCH-1:0] irq_en, status, expire_v, ch_hit, clr_mask;
    logic [DW-1:0]  ch_rd [NCH];

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_go    = bus_sel && bus_wr && aligned;
    assign clr_mask = (wr_go && bus_addr == STS_ADDR) ? bus_wdata[NCH-1:0] : '0;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int BASE_I = REG_BASE + REG_STRIDE * i;
        logic [2:0]    word;
        logic [7:0]    ctrl_q;
        logic [CW-1:0] ival, cnt;

        assign word      = 3'((bus_addr - AW'(BASE_I)) >> 2);
        assign ch_hit[i] = aligned && (int'(bus_addr) >= BASE_I)
                                   && (int'(bus_addr) < BASE_I + CH_SPAN);

        tmr_channel #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .PW(PW),
                      .SYNC(SYNC), .DW(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (wr_go && ch_hit[i] && word == 3'd0),
            .ilo_we   (wr_go && ch_hit[i] && word == 3'd1),
            .ihi_we   (wr_go && ch_hit[i] && word == 3'd2),
            .wdata    (bus_wdata),
            .ctrl_q   (ctrl_q),
            .interval (ival),
            .count    (cnt),
            .expire   (expire_v[i])
        );

        always_comb begin
            unique case (word)
                3'd0:    ch_rd[i] = DW'(ctrl_q);
                3'd1:    ch_rd[i] = DW'(ival[LOW_W-1:0]);
                3'd2:    ch_rd[i] = DW'(ival[CW-1:LOW_W]);
                3'd3:    ch_rd[i] = DW'(cnt[LOW_W-1:0]);
                3'd4:    ch_rd[i] = DW'(cnt[CW-1:LOW_W]);
                default: ch_rd[i] = '0;
            endcase
        end

        assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr_mask[i]) |=> status[i]);
        assert_expire_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
            expire_v[i] |=> status[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en <= '0;
            status <= '0;
        end else begin
            if (wr_go && bus_addr == IEN_ADDR) irq_en <= bus_wdata[NCH-1:0];
            status <= (status & ~clr_mask) | expire_v;
        end
    end

    assign irq = |(status & irq_en);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && aligned) begin
            if (bus_addr == IEN_ADDR) bus_rdata = DW'(irq_en);
            if (bus_addr == STS_ADDR) bus_rdata = DW'(status);
            for (int i = 0; i < NCH; i++) begin
                if (ch_hit[i]) bus_rdata = ch_rd[i];
            end
        end
    end

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);
endmodule

// File: tb/test_tmr_block.sv
module test_tmr_block;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    tmr_block i_tmr_block (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_status(input int bitn, output int n);
        logic [31:0] s;
        n = 0;
        rd(8'h04, s);
        while (!s[bitn] && n < 5000) begin
            @(negedge clk);
            n++;
            rd(8'h04, s);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, c0, c1;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, d); chk("R1 irq enable", d, 0);
        rd(8'h04, d); chk("R1 status", d, 0);
        rd(8'h10, d); chk("R1 ctrl0", d, 0);
        rd(8'h34, d); chk("R1 interval1", d, 0);
        rd(8'h1C, d); chk("R1 count0", d, 0);
        chk("R1 irq", irq, 0);

        // R2 decode
        wr(8'h34, 32'hA5A5_1234); rd(8'h34, d); chk("R2 interval lo readback", d, 32'hA5A5_1234);
        wr(8'h38, 32'hFFFF_FFFF); rd(8'h38, d); chk("R2 interval hi 24 bits", d, 32'h00FF_FFFF);
        wr(8'h3C, 32'h1234);      rd(8'h3C, d); chk("R2 count read-only", d, 0);
        wr(8'h08, 32'hFFFF);      rd(8'h08, d); chk("R2 unused reads zero", d, 0);
        wr(8'h15, 32'h7);         rd(8'h14, d); chk("R2 misaligned ignored", d, 0);
        wr(8'h38, 32'h0);

        // R3 control fields, R4 reload timing
        wr(8'h30, 32'hFFFF_FFF0); rd(8'h30, d); chk("R3 ctrl fields", d, 32'hF0);
        wr(8'h34, 32'h55);
        wr(8'h30, 32'h2);
        rd(8'h30, d);  chk("R3 reload reads zero", d, 0);
        rd(8'h3C, d);  chk("R4 count before copy", d, 0);
        @(negedge clk);
        rd(8'h3C, d);  chk("R4 count after copy", d, 32'h55);

        // R5 R6 R8 one-shot sweep over interval and prescaler
        for (int k = 0; k < 4; k++) begin
            for (int iv = 0; iv < 6; iv++) begin
                wr(8'h14, iv);
                wr(8'h10, 32'h83 | (k << 4));
                wait_status(0, n);
                chk($sformatf("R5 R6 latency k=%0d I=%0d", k, iv), n, 3 + ((iv + 1) << k));
                rd(8'h10, d); chk("R8 enable cleared", d & 1, 0);
                repeat (3) @(negedge clk);
                rd(8'h1C, d); chk("R8 count held at zero", d, 0);
                wr(8'h04, 1);
            end
        end

        // R7 periodic
        wr(8'h14, 2);
        wr(8'h10, 32'h13);
        wait_status(0, n); chk("R7 first expiry", n, 9);
        wr(8'h04, 1);
        wait_status(0, n); chk("R7 next period", n, 5);
        chk("R10 irq masked", irq, 0);

        // R11 disable drain
        wr(8'h10, 0);
        repeat (6) @(negedge clk);
        wr(8'h04, 1);
        wr(8'h14, 100);
        wr(8'h10, 32'h3);
        repeat (10) @(negedge clk);
        wr(8'h10, 0);
        rd(8'h10, d); chk("R3 enable clear readback", d & 1, 0);
        rd(8'h1C, c0);
        repeat (10) @(negedge clk);
        rd(8'h1C, c1); chk("R11 drain decrements", c0 - c1, 3);
        repeat (5) @(negedge clk);
        rd(8'h1C, d); chk("R11 stopped", d, c1);

        // R6 borrow across words
        wr(8'h14, 2); wr(8'h18, 1);
        wr(8'h10, 32'h3);
        repeat (7) @(negedge clk);
        rd(8'h1C, d); chk("R6 borrow low", d, 32'hFFFF_FFFE);
        rd(8'h20, d); chk("R6 borrow high", d, 0);
        rd(8'h1C, c0); @(negedge clk); rd(8'h1C, c1);
        chk("R6 inverted count rises", (~c1) - (~c0), 1);
        wr(8'h10, 0);
        repeat (6) @(negedge clk);
        wr(8'h04, 3);

        // R9 R10 on channel 1
        wr(8'h34, 1); wr(8'h38, 0);
        wr(8'h30, 32'h83);
        wait_status(1, n); chk("R5 channel1 latency", n, 5);
        chk("R10 irq off while disabled", irq, 0);
        wr(8'h00, 2); chk("R10 irq asserted", irq, 1);
        repeat (4) @(negedge clk); chk("R10 irq level holds", irq, 1);
        wr(8'h04, 0); rd(8'h04, d); chk("R9 zero write keeps flag", d, 2);
        wr(8'h04, 1); rd(8'h04, d); chk("R9 other bit keeps flag", d, 2);
        wr(8'h04, 2); rd(8'h04, d); chk("R9 one clears flag", d, 0);
        chk("R10 irq released", irq, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule